// File: doc/BRIEF.md
# Scan-Communication Access Bridge

This block sits between a 64-bit memory-mapped host register port and an internal scan-communication register bus. Each host access is turned into a register index by a shift-and-mask of the host byte address. A small fixed table of housekeeping indices is answered inside the bridge, so those accesses never reach the downstream bus. Any other index goes out on a valid/ready request channel at byte address `index << 3`, so every register takes one 8-byte slot. The bridge then waits for the single matching response.

Every access ends with one `host_ready` pulse. The outcome is also recorded as sticky flags in a two-bit status register: bit 0 is DONE and bit 1 is FAIL. The bridge only ever sets these bits. The host clears them by pulsing `stat_clr_valid` with ones in `stat_clr_mask` at the positions to clear. Only full eight-byte accesses are legal. Data words pass through whole, in big-endian byte order, with no byte lane steering.

Top module: `scom_bridge`

## Requirements
- R1: After reset, `status` is 0, `host_ready` is low and `ds_req_valid` is low.
- R2: The register index is `(host_addr >> IDX_SHIFT) & IDX_MASK`. A forwarded access drives `ds_req_addr` = index shifted left by 3, with `ds_req_we` equal to `host_write` and `ds_req_wdata` equal to `host_wdata`.
- R3: A full read of index 0xF000F returns the parameter `CHIP_ID`. A full write to 0xF000F is discarded. Neither one issues a downstream request, and each sets DONE only.
- R4: A full read of any of these indices returns zero with no downstream request and sets DONE only: 0x18002, 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, 0x2013F01, 0x2013F05, 0x2013028, 0x201302A, 0x2013801, 0x2013802, 0x2010828, 0x201082A, 0x2010841, 0x2010842, 0x4010828, 0x401082A, 0x4010841, 0x4010842. A read of any other index is forwarded, including 0x1010C01.
- R5: A full write to any of these indices is dropped with no downstream request and sets DONE only: 0x1010C00 to 0x1010C05, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, and the twelve link indices listed in R4 (0x2013028 through 0x4010842). A write to any other index is forwarded, including 0x18002 and 0x2013F01.
- R6: An access whose `host_be` is not 8'hFF is never forwarded. It sets FAIL and DONE, and a read returns zero.
- R7: A forwarded access that gets a response with `ds_rsp_err` low sets DONE only. A read returns `ds_rsp_rdata`.
- R8: A forwarded access that gets a response with `ds_rsp_err` high sets FAIL and DONE. A read returns zero.
- R9: `ds_req_valid` and its address, write-enable and data stay steady until `ds_req_ready`. No new request is raised until the previous one has been answered.
- R10: Status bits are sticky. A bit falls only on a clear pulse with a one at its position in `stat_clr_mask`. A bit that is set by an access ending in the same cycle as a clear pulse stays set.
- R11: `host_ready` is high for exactly one cycle per access. For a locally answered access it is high in the cycle after the access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until `host_ready` |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | IDX_W+IDX_SHIFT | Host byte address |
| host_be | input | 8 | Byte enables; only 8'hFF is legal |
| host_wdata | input | 64 | Host write data (big-endian word) |
| host_ready | output | 1 | One-cycle completion of the current access |
| host_rdata | output | 64 | Read data, valid with `host_ready` |
| ds_req_valid | output | 1 | Downstream request valid |
| ds_req_ready | input | 1 | Downstream accepts the request |
| ds_req_addr | output | IDX_W+3 | Downstream byte address (index << 3) |
| ds_req_we | output | 1 | Downstream write enable |
| ds_req_wdata | output | 64 | Downstream write data |
| ds_rsp_valid | input | 1 | Downstream response valid |
| ds_rsp_rdata | input | 64 | Downstream read data |
| ds_rsp_err | input | 1 | Downstream error flag |
| stat_clr_valid | input | 1 | Host clear pulse for status |
| stat_clr_mask | input | 2 | Ones mark status bits to clear |
| status | output | 2 | Sticky flags: bit 0 DONE, bit 1 FAIL |

## Verification
The bench builds the bridge with its default index geometry: a 28-bit index, a shift of 3 and an all-ones mask. With these values every housekeeping index in the tables can be reached, including the ones above 0x4000000. It sets `CHIP_ID` to a non-zero pattern, so a chip-identification read cannot be mistaken for a read-as-zero answer. The host address is given random low bits below the shift, which shows that they never reach the index. The downstream responder stalls for random times and returns an error for every index whose low nibble is 0xD. This brings both forwarded outcomes within reach of the random mix, along with the clear-versus-set collision.

// File: rtl/scom_bridge_pkg.sv
package scom_bridge_pkg;

  localparam int STAT_W   = 2;
  localparam int DONE_BIT = 0;
  localparam int FAIL_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } br_state_e;

  typedef enum logic [1:0] {
    LK_FWD,
    LK_ZERO,
    LK_CHIPID,
    LK_BAD
  } lk_kind_e;

  localparam logic [31:0] IDX_CHIPID = 32'h000F_000F;

  // link-unit indices that are answered locally both ways
  function automatic logic link_hit(input logic [31:0] i);
    return i inside {32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
                     32'h0201_0828, 32'h0201_082A, 32'h0201_0841, 32'h0201_0842,
                     32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842};
  endfunction

  // poll, reset-log and bus-unit indices shared by both directions
  function automatic logic common_hit(input logic [31:0] i);
    return i inside {32'h0102_0013, 32'h0102_0014, 32'h000F_0033, 32'h000F_0034,
                     32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
                     32'h0202_0007, 32'h0202_0009, 32'h0202_000F};
  endfunction

  function automatic logic rd_zero_hit(input logic [31:0] i);
    return common_hit(i) || link_hit(i) ||
           (i inside {32'h0001_8002, 32'h0101_0C00, 32'h0101_0C03,
                      32'h0201_3F01, 32'h0201_3F05});
  endfunction

  function automatic logic wr_drop_hit(input logic [31:0] i);
    return common_hit(i) || link_hit(i) || (i == IDX_CHIPID) ||
           (i >= 32'h0101_0C00 && i <= 32'h0101_0C05);
  endfunction

  // sticky status update: clear first, then set wins
  function automatic logic [STAT_W-1:0] stat_next(input logic [STAT_W-1:0] cur,
                                                  input logic [STAT_W-1:0] clr,
                                                  input logic [STAT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/scom_index_map.sv
module scom_index_map #(
  parameter int            IDX_W     = 28,
  parameter int            IDX_SHIFT = 3,
  parameter logic [IDX_W-1:0] IDX_MASK = '1,
  localparam int           HAW       = IDX_W + IDX_SHIFT,
  localparam int           DS_AW     = IDX_W + 3
) (
  input  logic [HAW-1:0]   addr,
  output logic [IDX_W-1:0] idx,
  output logic [DS_AW-1:0] ds_addr
);

  function automatic logic [IDX_W-1:0] to_index(input logic [HAW-1:0] a);
    return a[IDX_SHIFT +: IDX_W] & IDX_MASK;
  endfunction

  logic unused_low_bits;
  assign unused_low_bits = ^addr[IDX_SHIFT-1:0];

  assign idx     = to_index(addr);
  assign ds_addr = {idx, 3'b000};

endmodule

// File: rtl/scom_intercept.sv
module scom_intercept
  import scom_bridge_pkg::*;
#(
  parameter int IDX_W = 28
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             is_write,
  input  logic [7:0]       be,
  output lk_kind_e         kind
);

  logic [31:0] idx32;
  logic        full_word;

  assign idx32     = 32'(idx);
  assign full_word = (be == 8'hFF);

  always_comb begin
    if (!full_word)                 kind = LK_BAD;
    else if (is_write)              kind = wr_drop_hit(idx32) ? LK_ZERO : LK_FWD;
    else if (idx32 == IDX_CHIPID)   kind = LK_CHIPID;
    else if (rd_zero_hit(idx32))    kind = LK_ZERO;
    else                            kind = LK_FWD;
  end

endmodule

// File: rtl/scom_status.sv
module scom_status
  import scom_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_done,
  input  logic              set_fail,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status
);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[DONE_BIT] = set_done;
    set_vec[FAIL_BIT] = set_fail;
    clr_vec           = clr_valid ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= stat_next(status, clr_vec, set_vec);
  end

endmodule

// File: rtl/scom_bridge.sv
module scom_bridge
  import scom_bridge_pkg::*;
#(
  parameter int               IDX_W     = 28,
  parameter int               IDX_SHIFT = 3,
  parameter logic [IDX_W-1:0] IDX_MASK  = '1,
  parameter logic [63:0]      CHIP_ID   = 64'h0000_0000_0000_00D1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_valid,
  input  logic                       host_write,
  input  logic [IDX_W+IDX_SHIFT-1:0] host_addr,
  input  logic [7:0]                 host_be,
  input  logic [63:0]                host_wdata,
  output logic                       host_ready,
  output logic [63:0]                host_rdata,
  output logic                       ds_req_valid,
  input  logic                       ds_req_ready,
  output logic [IDX_W+2:0]           ds_req_addr,
  output logic                       ds_req_we,
  output logic [63:0]                ds_req_wdata,
  input  logic                       ds_rsp_valid,
  input  logic [63:0]                ds_rsp_rdata,
  input  logic                       ds_rsp_err,
  input  logic                       stat_clr_valid,
  input  logic [1:0]                 stat_clr_mask,
  output logic [1:0]                 status
);

  localparam int HAW   = IDX_W + IDX_SHIFT;
  localparam int DS_AW = IDX_W + 3;

  br_state_e        st_q;
  logic [HAW-1:0]   addr_q;
  logic             write_q;
  logic [7:0]       be_q;
  logic [63:0]      wdata_q;
  logic [63:0]      rsp_data_q;
  logic             rsp_err_q;

  logic [IDX_W-1:0] idx;
  logic [DS_AW-1:0] ds_addr;
  lk_kind_e         kind;

  // named internal events for the checker
  logic             evt_local;
  logic             evt_done;
  logic             evt_fail;
  logic             fwd_wait;

  scom_index_map #(
    .IDX_W     (IDX_W),
    .IDX_SHIFT (IDX_SHIFT),
    .IDX_MASK  (IDX_MASK)
  ) map_i (
    .addr    (addr_q),
    .idx     (idx),
    .ds_addr (ds_addr)
  );

  scom_intercept #(
    .IDX_W (IDX_W)
  ) icpt_i (
    .idx      (idx),
    .is_write (write_q),
    .be       (be_q),
    .kind     (kind)
  );

  assign evt_local = (st_q == ST_LOOK) && (kind != LK_FWD);
  assign evt_done  = evt_local || (st_q == ST_DONE);
  assign evt_fail  = (evt_local && kind == LK_BAD) || ((st_q == ST_DONE) && rsp_err_q);
  assign fwd_wait  = (st_q == ST_WAIT);

  scom_status stat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_done  (evt_done),
    .set_fail  (evt_fail),
    .clr_valid (stat_clr_valid),
    .clr_mask  (stat_clr_mask),
    .status    (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      write_q    <= 1'b0;
      be_q       <= '0;
      wdata_q    <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (host_valid) begin
          addr_q  <= host_addr;
          write_q <= host_write;
          be_q    <= host_be;
          wdata_q <= host_wdata;
          st_q    <= ST_LOOK;
        end
        ST_LOOK: st_q <= (kind == LK_FWD) ? ST_REQ : ST_IDLE;
        ST_REQ:  if (ds_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (ds_rsp_valid) begin
          rsp_data_q <= ds_rsp_rdata;
          rsp_err_q  <= ds_rsp_err;
          st_q       <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    host_rdata = '0;
    if (evt_local && kind == LK_CHIPID)
      host_rdata = CHIP_ID;
    else if (st_q == ST_DONE && !write_q && !rsp_err_q)
      host_rdata = rsp_data_q;
  end

  assign host_ready   = evt_done;
  assign ds_req_valid = (st_q == ST_REQ);
  assign ds_req_addr  = ds_addr;
  assign ds_req_we    = write_q;
  assign ds_req_wdata = wdata_q;

endmodule

// File: rtl/scom_bridge_chk.sv
module scom_bridge_chk #(
  parameter int DS_AW = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_valid,
  input logic             host_ready,
  input logic             host_write,
  input logic [63:0]      host_rdata,
  input logic             ds_req_valid,
  input logic             ds_req_ready,
  input logic [DS_AW-1:0] ds_req_addr,
  input logic             ds_req_we,
  input logic [63:0]      ds_req_wdata,
  input logic [1:0]       status,
  input logic             stat_clr_valid,
  input logic [1:0]       stat_clr_mask,
  input logic             evt_fail,
  input logic             fwd_wait
);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req_valid && !ds_req_ready) |=> (ds_req_valid && $stable(ds_req_addr) &&
                                         $stable(ds_req_we) && $stable(ds_req_wdata)));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wait |-> !ds_req_valid);

  assert_req_not_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req_valid |-> !host_ready);

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  assert_done_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |=> status[0]);

  assert_done_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(stat_clr_valid && stat_clr_mask[0]));

  assert_fail_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(stat_clr_valid && stat_clr_mask[1]));

  assert_fail_zero_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && evt_fail && !host_write) |-> (host_rdata == 64'd0));

  assert_fail_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && evt_fail) |=> status[1]);

endmodule

bind scom_bridge scom_bridge_chk #(.DS_AW(IDX_W + 3)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_valid     (host_valid),
  .host_ready     (host_ready),
  .host_write     (host_write),
  .host_rdata     (host_rdata),
  .ds_req_valid   (ds_req_valid),
  .ds_req_ready   (ds_req_ready),
  .ds_req_addr    (ds_req_addr),
  .ds_req_we      (ds_req_we),
  .ds_req_wdata   (ds_req_wdata),
  .status         (status),
  .stat_clr_valid (stat_clr_valid),
  .stat_clr_mask  (stat_clr_mask),
  .evt_fail       (evt_fail),
  .fwd_wait       (fwd_wait)
);

// File: tb/scom_bridge_tb_top.sv
module scom_bridge_tb_top;

  localparam int          IDX_W  = 28;
  localparam int          SHIFT  = 3;
  localparam logic [63:0] CHIPID = 64'hC0DE_5A17_0042_9E01;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_valid = 1'b0;
  logic              host_write = 1'b0;
  logic [IDX_W+SHIFT-1:0] host_addr = '0;
  logic [7:0]        host_be = 8'hFF;
  logic [63:0]       host_wdata = '0;
  logic              host_ready;
  logic [63:0]       host_rdata;
  logic              ds_req_valid;
  logic              ds_req_ready = 1'b0;
  logic [IDX_W+2:0]  ds_req_addr;
  logic              ds_req_we;
  logic [63:0]       ds_req_wdata;
  logic              ds_rsp_valid = 1'b0;
  logic [63:0]       ds_rsp_rdata = '0;
  logic              ds_rsp_err = 1'b0;
  logic              stat_clr_valid = 1'b0;
  logic [1:0]        stat_clr_mask = '0;
  logic [1:0]        status;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int               req_cnt = 0;
  logic [IDX_W+2:0] last_addr;
  logic             last_we;
  logic [63:0]      last_wd;

  always #4 clk = ~clk;

  scom_bridge #(
    .IDX_W     (IDX_W),
    .IDX_SHIFT (SHIFT),
    .CHIP_ID   (CHIPID)
  ) dut_i (.*);

  function automatic logic [63:0] ds_data(input logic [IDX_W+2:0] a);
    return {32'(a) ^ 32'h5A5A_0F0F, ~32'(a)};
  endfunction

  function automatic bit ds_fail(input logic [IDX_W+2:0] a);
    return a[6:3] == 4'hD;
  endfunction

  function automatic bit b_link(input logic [27:0] i);
    logic [11:0] lo = i[11:0];
    return ((i[27:12] == 16'h2013) && (lo inside {12'h028, 12'h02A, 12'h801, 12'h802})) ||
           ((i[27:12] == 16'h2010 || i[27:12] == 16'h4010) &&
            (lo inside {12'h828, 12'h82A, 12'h841, 12'h842}));
  endfunction

  function automatic bit b_shared(input logic [27:0] i);
    return i inside {28'h0090012, 28'h0090013, 28'h0090018, 28'h1020013, 28'h1020014,
                     28'h00F0033, 28'h00F0034, 28'h2020007, 28'h2020009, 28'h202000F};
  endfunction

  function automatic bit b_rd_zero(input logic [27:0] i);
    return b_shared(i) || b_link(i) ||
           i inside {28'h0018002, 28'h2013F01, 28'h2013F05, 28'h1010C00, 28'h1010C03};
  endfunction

  function automatic bit b_wr_drop(input logic [27:0] i);
    return b_shared(i) || b_link(i) || i == 28'h00F000F ||
           (i[27:4] == 24'h1010C0 && i[3:0] <= 4'h5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_status(input logic [1:0] m);
    @(negedge clk);
    stat_clr_valid = 1'b1;
    stat_clr_mask  = m;
    @(negedge clk);
    stat_clr_valid = 1'b0;
    stat_clr_mask  = '0;
  endtask

  task automatic host_access(input bit wr, input logic [27:0] idx, input logic [7:0] be,
                             input logic [63:0] wd, input bit clr_same,
                             output logic [63:0] rd, output int lat);
    @(negedge clk);
    host_valid = 1'b1;
    host_write = wr;
    host_addr  = {idx, 3'($urandom)};
    host_be    = be;
    host_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ready && lat < 1000);
    rd = host_rdata;
    if (clr_same) begin
      stat_clr_valid = 1'b1;
      stat_clr_mask  = 2'b11;
    end
    @(negedge clk);
    host_valid     = 1'b0;
    stat_clr_valid = 1'b0;
    stat_clr_mask  = '0;
  endtask

  // full checked access starting from a cleared status
  task automatic run_one(input bit wr, input logic [27:0] idx, input logic [7:0] be,
                         input logic [63:0] wd);
    logic [63:0] rd;
    int lat;
    int c0;
    bit is_local;
    logic [63:0] exp_rd;
    logic [1:0]  exp_st;
    logic [IDX_W+2:0] exp_a;
    clear_status(2'b11);
    c0 = req_cnt;
    exp_a = {idx, 3'b000};
    host_access(wr, idx, be, wd, 1'b0, rd, lat);
    if (be != 8'hFF) begin
      is_local = 1; exp_rd = '0; exp_st = 2'b11;
      check(req_cnt == c0, "R6 no forward", 64'(req_cnt - c0), 0);
    end else if (wr ? b_wr_drop(idx) : (b_rd_zero(idx) || idx == 28'h00F000F)) begin
      is_local = 1; exp_st = 2'b01;
      exp_rd = (!wr && idx == 28'h00F000F) ? CHIPID : 64'd0;
      check(req_cnt == c0, "R3/R4/R5 local no forward", 64'(req_cnt - c0), 0);
    end else begin
      is_local = 0;
      exp_st = ds_fail(exp_a) ? 2'b11 : 2'b01;
      exp_rd = ds_fail(exp_a) ? 64'd0 : ds_data(exp_a);
      check(req_cnt == c0 + 1, "R2 one forward", 64'(req_cnt - c0), 1);
      check(last_addr == exp_a && last_we == wr, "R2 ds addr", 64'(last_addr), 64'(exp_a));
      if (wr) check(last_wd == wd, "R2 ds wdata", last_wd, wd);
    end
    if (!wr) check(rd == exp_rd, "R3/R4/R6/R7/R8 rdata", rd, exp_rd);
    check(status == exp_st, "R6/R7/R8/R10 status", 64'(status), 64'(exp_st));
    if (is_local) check(lat == 1, "R11 local latency", 64'(lat), 1);
  endtask

  // downstream responder with random stalls
  initial begin
    forever begin
      @(negedge clk);
      if (ds_req_valid) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        ds_req_ready = 1'b1;
        last_addr = ds_req_addr;
        last_we   = ds_req_we;
        last_wd   = ds_req_wdata;
        req_cnt++;
        @(negedge clk);
        ds_req_ready = 1'b0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        ds_rsp_valid = 1'b1;
        ds_rsp_rdata = ds_data(last_addr);
        ds_rsp_err   = ds_fail(last_addr);
        @(negedge clk);
        ds_rsp_valid = 1'b0;
        ds_rsp_err   = 1'b0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [27:0] PICKS [0:15] = '{
    28'h00F000F, 28'h0018002, 28'h1010C00, 28'h1010C01, 28'h1010C03, 28'h1010C05,
    28'h1020014, 28'h00F0033, 28'h0090018, 28'h202000F, 28'h2013F01, 28'h2013F05,
    28'h201302A, 28'h4010842, 28'h2010828, 28'h000123D};

  initial begin
    logic [63:0] rd;
    int lat;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(status == 2'b00, "R1 status reset", 64'(status), 0);
    check(!host_ready, "R1 ready reset", 64'(host_ready), 0);
    check(!ds_req_valid, "R1 req reset", 64'(ds_req_valid), 0);
    rst_n = 1'b1;

    run_one(1'b0, 28'h00F000F, 8'hFF, '0);                 // R3 read
    run_one(1'b1, 28'h00F000F, 8'hFF, 64'h1111_2222_3333_4444); // R3 write
    run_one(1'b0, 28'h00F000F, 8'hFF, '0);                 // R3 unchanged
    run_one(1'b0, 28'h4010841, 8'hFF, '0);                 // R4
    run_one(1'b0, 28'h0090013, 8'hFF, '0);                 // R4
    run_one(1'b0, 28'h1010C01, 8'hFF, '0);                 // R4 forwarded
    run_one(1'b1, 28'h1010C04, 8'hFF, 64'hDEAD_BEEF_0000_0001); // R5
    run_one(1'b1, 28'h0018002, 8'hFF, 64'h0123_4567_89AB_CDEF); // R5 forwarded
    run_one(1'b0, 28'h0018002, 8'h0F, '0);                 // R6
    run_one(1'b1, 28'h1234567, 8'hFE, 64'h5);              // R6
    run_one(1'b0, 28'h0ABC120, 8'hFF, '0);                 // R7
    run_one(1'b1, 28'h0ABC121, 8'hFF, 64'hFEED_F00D_CAFE_0001); // R7
    run_one(1'b0, 28'h000123D, 8'hFF, '0);                 // R8
    run_one(1'b1, 28'h7FFFFFD, 8'hFF, 64'h77);             // R8

    // R10: stickiness across accesses and selective clear
    clear_status(2'b11);
    host_access(1'b0, 28'h000555D, 8'hFF, '0, 1'b0, rd, lat);
    host_access(1'b0, 28'h0018002, 8'hFF, '0, 1'b0, rd, lat);
    check(status == 2'b11, "R10 fail sticks", 64'(status), 3);
    clear_status(2'b01);
    check(status == 2'b10, "R10 clear done only", 64'(status), 2);
    clear_status(2'b10);
    check(status == 2'b00, "R10 clear fail", 64'(status), 0);
    // R10: set beats clear in the same cycle
    host_access(1'b0, 28'h0018002, 8'hFF, '0, 1'b1, rd, lat);
    check(status == 2'b01, "R10 set wins over clear", 64'(status), 1);
    host_access(1'b0, 28'h0018002, 8'hFF, '0, 1'b0, rd, lat);
    repeat (4) @(negedge clk);
    check(status == 2'b01, "R10 holds without clear", 64'(status), 1);

    for (int k = 0; k < 300; k++) begin
      logic [27:0] idx;
      logic [7:0]  be;
      if ($urandom_range(0, 9) < 4) idx = PICKS[$urandom_range(0, 15)];
      else                          idx = 28'($urandom);
      be = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hFF;
      run_one(1'($urandom), idx, be, {$urandom, $urandom});
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule